// File: doc/BRIEF.md
# Pulse Width Capture Timer Channel

This block is one 16-bit timer channel that measures how long a timer input stays high, or how long it stays low. The raw input is first passed through a synchroniser clocked by the operating clock. Edges are then found by comparing each synchronised sample with the one before it. A software start pulse enables the channel and arms it. The channel then waits for the edge that opens a measurement. That edge clears the counter, and from then on every count-enable tick adds one. The opposite edge ends the measurement. It copies the count into the capture register, raises a one-cycle interrupt and rewrites the overflow flag.

After a capture the counter stops at the captured value plus one. The channel re-arms by itself for the next opening edge, so a stream of pulses is measured without further software action. The width in tick periods is 65536 × overflow + capture + 1. If the counter wrapped more than once, the overflow flag is still only a single bit, so the true width is lost. A stop pulse disables the channel at any time and leaves the last result untouched.

Top module: `pwcap_channel`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `en_o`, `irq_o` and `ovf_o` are 0, and `cap_o` and `cnt_o` are 0.
- R2: A `start_i` pulse while the channel is disabled sets `en_o` one cycle later and arms the channel. A `start_i` pulse while `en_o` is 1 has no effect: a measurement in progress is neither restarted nor disturbed.
- R3: With `mode_i` = 2'b11, a rising edge opens a measurement and a falling edge closes it. When ticks arrive every cycle, a high phase of W cycles gives `cap_o` = W-1.
- R4: With `mode_i` = 2'b10, a falling edge opens a measurement and a rising edge closes it. When ticks arrive every cycle, a low phase of W cycles gives `cap_o` = W-1.
- R5: `irq_o` is a one-cycle pulse. `cap_o` and `ovf_o` take their new values in that same cycle and change at no other time. The pulse rises after the third rising clock edge that follows a change on `pin_i`.
- R6: After a capture, `cnt_o` holds `cap_o` + 1 (modulo 2^16) and the channel re-arms. The next pulse is measured without a new `start_i`.
- R7: Every capture rewrites `ovf_o`. It becomes 1 if the counter wrapped from 16'hFFFF to 0 during that measurement, and 0 otherwise. A width of exactly 65536 ticks gives `cap_o` = 16'hFFFF with `ovf_o` = 0, and 65538 gives `cap_o` = 1 with `ovf_o` = 1.
- R8: The counter advances only in cycles where `tick_i` is 1. With `tick_i` held at 0, any pulse captures 0.
- R9: A `stop_i` pulse clears `en_o` one cycle later and takes priority over `start_i`. It leaves `cap_o`, `ovf_o` and `cnt_o` unchanged, and edges that follow it produce no capture and no interrupt.
- R10: When `mode_i[1]` is 0, no edge opens a measurement, so no capture or interrupt ever occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one tick per count period |
| start_i | input | 1 | Software start pulse |
| stop_i | input | 1 | Software stop pulse |
| mode_i | input | 2 | 2'b11 high-width, 2'b10 low-width, 2'b0x inactive |
| pin_i | input | 1 | Raw asynchronous timer input |
| cnt_o | output | 16 | Current counter value |
| cap_o | output | 16 | Captured count of the last measurement |
| ovf_o | output | 1 | Overflow status of the last capture |
| en_o | output | 1 | Channel enable flag |
| irq_o | output | 1 | One-cycle capture interrupt |

## Verification
A corrupted state register shows up at the ports right away. A channel that fails to re-arm gives no `irq_o` on the next pulse, three edges after the closing edge. A channel that re-arms too early restarts the count from zero, so the capture comes out short. A counter that slips or ignores `tick_i` shows as a wrong `cap_o` at the very next interrupt. A faulty wrap flag stays hidden until the capture that ends the long measurement, so the bench runs pulses at both sides of the 65536-tick boundary. Stop and start misuse is checked through `en_o` one cycle after the pulse, and through the missing or undisturbed capture that follows.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } pw_state_e;

   localparam logic [1:0] MODE_LOW_W  = 2'b10;
   localparam logic [1:0] MODE_HIGH_W = 2'b11;
endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pwcap_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwcap_edge.sv
module pwcap_edge
   import pwcap_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       lvl_i,
   input  logic [1:0] mode_i,
   output logic       open_ev_o,
   output logic       close_ev_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic prev_q;
   logic rise, fall, active, high_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i;
   end

   always_comb begin
      rise       = lvl_i & ~prev_q;
      fall       = ~lvl_i & prev_q;
      active     = mode_i[1];
      high_w     = (mode_i == MODE_HIGH_W);
      open_ev_o  = active & (high_w ? rise : fall);
      close_ev_o = active & (high_w ? fall : rise);
   end
endmodule

// File: rtl/pwcap_core.sv
module pwcap_core
   import pwcap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             open_ev_i,
   input  logic             close_ev_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             ovf_o,
   output logic             en_o,
   output logic             irq_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   pw_state_e        st_q;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic             wrap_q, ovf_q, irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         cap_q  <= '0;
         wrap_q <= 1'b0;
         ovf_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (start_i) st_q <= ST_ARMED;
               end
               ST_ARMED: begin
                  if (open_ev_i) begin
                     cnt_q  <= '0;
                     wrap_q <= 1'b0;
                     st_q   <= ST_RUN;
                  end
               end
               ST_RUN: begin
                  if (close_ev_i) begin
                     cap_q <= cnt_q;
                     ovf_q <= wrap_q;
                     irq_q <= 1'b1;
                     cnt_q <= cnt_q + CNT_ONE;
                     st_q  <= ST_ARMED;
                  end else if (tick_i) begin
                     cnt_q <= cnt_q + CNT_ONE;
                     if (cnt_q == CNT_MAX) wrap_q <= 1'b1;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign cnt_o = cnt_q;
   assign cap_o = cap_q;
   assign ovf_o = ovf_q;
   assign en_o  = (st_q != ST_IDLE);
   assign irq_o = irq_q;
endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [1:0]       mode_i,
   input  logic             pin_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             ovf_o,
   output logic             en_o,
   output logic             irq_o
);
   timeunit 1ns;
   timeprecision 100ps;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("pwcap_channel: CNT_W must lie in 2..32");
      end
   endgenerate

   logic pin_s, open_ev, close_ev;

   pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i),
      .q_o    (pin_s)
   );

   pwcap_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (pin_s),
      .mode_i     (mode_i),
      .open_ev_o  (open_ev),
      .close_ev_o (close_ev)
   );

   pwcap_core #(.CNT_W(CNT_W)) u_core (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .start_i    (start_i),
      .stop_i     (stop_i),
      .open_ev_i  (open_ev),
      .close_ev_i (close_ev),
      .cnt_o      (cnt_o),
      .cap_o      (cap_o),
      .ovf_o      (ovf_o),
      .en_o       (en_o),
      .irq_o      (irq_o)
   );
endmodule

// File: rtl/pwcap_channel_chk.sv
module pwcap_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic             start_i,
   input logic             stop_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CNT_W-1:0] cap_o,
   input logic             ovf_o,
   input logic             en_o,
   input logic             irq_o
);
   timeunit 1ns;
   timeprecision 100ps;

   p_start_sets_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !stop_i) |=> en_o);

   p_irq_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> en_o);

   p_hold_plus_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (cnt_o == CNT_W'(cap_o + 1'b1)));

   p_result_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> ($stable(cap_o) && $stable(ovf_o)));

   p_tick_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> ($stable(cnt_o) || cnt_o == '0 || irq_o));

   p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!en_o && $stable(cap_o) && $stable(ovf_o) && $stable(cnt_o)));
endmodule

bind pwcap_channel pwcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick_i  (tick_i),
   .start_i (start_i),
   .stop_i  (stop_i),
   .cnt_o   (cnt_o),
   .cap_o   (cap_o),
   .ovf_o   (ovf_o),
   .en_o    (en_o),
   .irq_o   (irq_o)
);

// File: tb/pwcap_channel_tb_top.sv
module pwcap_channel_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic [1:0]    mode = 2'b11;
   logic          pin = 1'b0;
   logic [CW-1:0] cnt, cap;
   logic          ovf, en, irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pwcap_channel #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
      .mode_i(mode), .pin_i(pin), .cnt_o(cnt), .cap_o(cap), .ovf_o(ovf),
      .en_o(en), .irq_o(irq)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic arm();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic halt();
      @(negedge clk) stop = 1'b1;
      @(negedge clk) stop = 1'b0;
   endtask

   task automatic idle_at(input logic [1:0] m, input logic lvl);
      halt();
      mode = m;
      pin  = lvl;
      repeat (6) @(negedge clk);
   endtask

   // called right after the negedge that drove the closing edge
   task automatic expect_capture(input string tag, input longint exp_cap, input logic exp_ovf);
      repeat (2) @(posedge clk);
      #1 chk({tag, " R5 no early irq"}, irq, 0);
      @(posedge clk);
      #1 chk({tag, " R5 irq on third edge"}, irq, 1);
      chk({tag, " capture value"}, cap, exp_cap);
      chk({tag, " R7 overflow flag"}, ovf, exp_ovf);
      @(posedge clk);
      #1 chk({tag, " R5 irq single cycle"}, irq, 0);
      repeat (3) @(posedge clk);
      #1 chk({tag, " R6 counter holds cap+1"}, cnt, (exp_cap + 1) % 65536);
   endtask

   task automatic pulse(input logic active, input int w);
      @(negedge clk) pin = active;
      repeat (w) @(negedge clk);
      pin = ~active;
   endtask

   task automatic no_irq_for(input string tag, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1 if (irq) seen++;
      end
      chk(tag, seen, 0);
   endtask

   task automatic t_reset();
      repeat (4) @(posedge clk);
      #1;
      chk("R1 en in reset", en, 0);
      chk("R1 irq in reset", irq, 0);
      chk("R1 ovf in reset", ovf, 0);
      chk("R1 cap in reset", cap, 0);
      chk("R1 cnt in reset", cnt, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 chk("R1 en after release", en, 0);
   endtask

   task automatic t_high();
      mode = 2'b11; pin = 1'b0;
      repeat (4) @(negedge clk);
      arm();
      #1 chk("R2 start sets en", en, 1);
      pulse(1'b1, 10);
      expect_capture("R3 high width 10", 9, 1'b0);
   endtask

   task automatic t_rearm();
      repeat (3) @(negedge clk);
      pulse(1'b1, 3);
      expect_capture("R6 rearm width 3", 2, 1'b0);
   endtask

   task automatic t_low();
      idle_at(2'b10, 1'b1);
      arm();
      pulse(1'b0, 7);
      expect_capture("R4 low width 7", 6, 1'b0);
      pulse(1'b0, 1);
      expect_capture("R4 low width 1", 0, 1'b0);
   endtask

   task automatic t_start_ignored();
      idle_at(2'b11, 1'b0);
      arm();
      @(negedge clk) pin = 1'b1;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (7) @(negedge clk);
      pin = 1'b0;
      expect_capture("R2 start ignored while enabled", 11, 1'b0);
      chk("R2 en still set", en, 1);
   endtask

   task automatic t_tick();
      tick = 1'b0;
      pulse(1'b1, 20);
      expect_capture("R8 no ticks", 0, 1'b0);
      tick = 1'b1;
   endtask

   task automatic t_wrap();
      pulse(1'b1, 65536);
      expect_capture("R7 width 65536", 65535, 1'b0);
      pulse(1'b1, 65538);
      expect_capture("R7 width 65538", 1, 1'b1);
      pulse(1'b1, 5);
      expect_capture("R7 ovf cleared", 4, 1'b0);
   endtask

   task automatic t_stop();
      logic [CW-1:0] held;
      @(negedge clk) pin = 1'b1;
      repeat (8) @(negedge clk);
      stop = 1'b1;
      @(negedge clk) stop = 1'b0;
      #1 chk("R9 stop clears en", en, 0);
      held = cnt;
      pin = 1'b0;
      no_irq_for("R9 no irq after stop", 10);
      chk("R9 cap kept", cap, 4);
      chk("R9 ovf kept", ovf, 0);
      chk("R9 cnt frozen", cnt, held);
   endtask

   task automatic t_mode_off();
      mode = 2'b01; pin = 1'b0;
      repeat (4) @(negedge clk);
      arm();
      pulse(1'b1, 6);
      no_irq_for("R10 inactive mode gives no irq", 10);
      chk("R10 cap untouched", cap, 4);
      halt();
   endtask

   initial begin
      t_reset();
      t_high();
      t_rearm();
      t_low();
      t_start_ignored();
      t_tick();
      t_wrap();
      t_stop();
      t_mode_off();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual expired expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule